// File: doc/BRIEF.md
# Per-Pixel Shading Corrector

This block is the digital back end that flattens the response of a linear image sensor. Pixels arrive as 16-bit samples, each tagged with its position along the line and a colour number. For every pixel the block removes a dark level and then scales the result by a gain coefficient. The dark level is the sum of a per-pixel offset and one of two line-wide offsets, picked by whether the pixel position is odd or even. Each colour keeps its own set of per-pixel offsets and gains, so calibration is done one colour at a time.

To calibrate a colour, the front end is set to zero offset and unity gain and a dark line is scanned with `cap_dark` held high. In that mode every incoming sample is stored directly as the offset for its colour and position, and no corrected pixel comes out. A white line is then scanned, the gains are worked out elsewhere, and they are written one by one through the host port. The same port can also overwrite single offsets.

The datapath has three register stages. A valid flag travels with each pixel, and the pixel's colour and position come out with the corrected value.

Top module: `shade_corr_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `out_pix` is 0.
- R2: A pixel accepted at a rising edge (`in_valid`=1, `cap_dark`=0, `in_col`<3) shows up with `out_valid`=1 exactly three rising edges later, with its `in_col` and `in_idx` on `out_col`/`out_idx`. Back-to-back pixels come out back to back.
- R3: `out_pix` = min(0xFFFF, floor((D*G + 0x2000) / 2^14)). D is the clamped difference from R4 and G is the gain, unsigned with 2 integer and 14 fraction bits (0x4000 = 1.0), so results round half up.
- R4: D = `in_pix` − (stored offset + parity offset) when that is positive, and 0 otherwise.
- R5: When the rounded product exceeds 0xFFFF, `out_pix` is 0xFFFF.
- R6: The parity offset is `par_ofs_odd` when `in_idx` bit 0 is 1, and `par_ofs_even` when it is 0.
- R7: While `cap_dark`=1, each valid pixel's `in_pix` is written as the offset for (`in_col`,`in_idx`), and `out_valid` stays 0 for that pixel.
- R8: With `host_we`=1, `host_data` is written to entry (`host_col`,`host_idx`): the offset when `host_sel`=0, the gain when `host_sel`=1. A pixel presented in the next cycle already uses the new value.
- R9: Each of colours 0, 1 and 2 has its own coefficients. Pixels with `in_col`=3 produce no output, and host writes with `host_col`=3 are dropped.
- R10: In any cycle where `out_valid` is 0, `out_pix` keeps its previous value.
- R11: If a dark-capture write and a host offset write happen in the same cycle, the dark-capture write is the one stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_dark | input | 1 | Dark-line capture mode |
| par_ofs_odd | input | 16 | Extra offset for odd positions |
| par_ofs_even | input | 16 | Extra offset for even positions |
| host_we | input | 1 | Host coefficient write strobe |
| host_sel | input | 1 | 0 = offset, 1 = gain |
| host_col | input | 2 | Colour of the host write |
| host_idx | input | 10 | Pixel position of the host write |
| host_data | input | 16 | Coefficient value |
| in_valid | input | 1 | Input pixel valid |
| in_col | input | 2 | Input colour (0..2) |
| in_idx | input | 10 | Input pixel position |
| in_pix | input | 16 | Input sample |
| out_valid | output | 1 | Corrected pixel valid |
| out_col | output | 2 | Colour of the corrected pixel |
| out_idx | output | 10 | Position of the corrected pixel |
| out_pix | output | 16 | Corrected sample |

## Verification
The assertions take `cap_dark` and the inputs to be held at 0 during reset. They also assume `cap_dark` changes only between pixels, so the three-cycle relation between an accepted input and `out_valid` can be checked with a fixed look-back. The stimulus follows both rules: every input changes only on falling edges, `cap_dark` toggles only while the pipeline is empty, and every coefficient entry a test reads is written first, because the coefficient storage has no reset value.

// File: rtl/shade_pkg.sv
package shade_pkg;
  typedef enum logic {
    SEL_OFS  = 1'b0,
    SEL_GAIN = 1'b1
  } coef_sel_e;
endpackage

// File: rtl/shade_coef_mem.sv
module shade_coef_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 3072,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/shade_sub.sv
module shade_sub #(
  parameter int W = 16
) (
  input  logic [W-1:0] pix,
  input  logic [W-1:0] ofs,
  input  logic [W-1:0] pofs,
  output logic [W-1:0] diff
);
  logic [W:0] total;

  always_comb begin
    total = {1'b0, ofs} + {1'b0, pofs};
    if ({1'b0, pix} > total) diff = pix - total[W-1:0];
    else                     diff = '0;
  end
endmodule

// File: rtl/shade_mul.sv
module shade_mul #(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic [W-1:0] diff,
  input  logic [W-1:0] gain,
  output logic [W-1:0] res
);
  localparam int PW = 2 * W + 1;
  logic [PW-1:0] prod;
  logic [PW-1:0] scaled;

  always_comb begin
    prod   = PW'(diff) * PW'(gain) + (PW'(1) << (FRAC - 1));
    scaled = prod >> FRAC;
    if (|scaled[PW-1:W]) res = '1;
    else                 res = scaled[W-1:0];
  end
endmodule

// File: rtl/shade_corr_top.sv
module shade_corr_top #(
  parameter int PIX_W     = 16,
  parameter int PIX_DEPTH = 1024,
  parameter int NCOL      = 3,
  parameter int FRAC      = 14,
  parameter int IDX_W     = $clog2(PIX_DEPTH),
  parameter int COL_W     = $clog2(NCOL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_dark,
  input  logic [PIX_W-1:0] par_ofs_odd,
  input  logic [PIX_W-1:0] par_ofs_even,
  input  logic             host_we,
  input  logic             host_sel,
  input  logic [COL_W-1:0] host_col,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [PIX_W-1:0] host_data,
  input  logic             in_valid,
  input  logic [COL_W-1:0] in_col,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic [COL_W-1:0] out_col,
  output logic [IDX_W-1:0] out_idx,
  output logic [PIX_W-1:0] out_pix
);
  import shade_pkg::*;

  localparam int MEM_DEPTH = NCOL * PIX_DEPTH;
  localparam int AW        = $clog2(MEM_DEPTH);

  function automatic logic [AW-1:0] coef_addr(input logic [COL_W-1:0] c,
                                              input logic [IDX_W-1:0] i);
    return AW'(c) * AW'(PIX_DEPTH) + AW'(i);
  endfunction

  // write / read control
  logic          in_col_ok, host_col_ok, px_take, dk_we;
  logic          ofs_we, gain_we;
  logic [AW-1:0] px_addr, host_addr, ofs_waddr;
  logic [PIX_W-1:0] ofs_wdata, ofs_rd, gain_rd;

  always_comb begin
    in_col_ok   = in_col < COL_W'(NCOL);
    host_col_ok = host_col < COL_W'(NCOL);
    px_addr     = coef_addr(in_col, in_idx);
    host_addr   = coef_addr(host_col, host_idx);
    px_take     = in_valid && in_col_ok && !cap_dark;
    dk_we       = in_valid && in_col_ok && cap_dark;
    ofs_we      = dk_we || (host_we && host_col_ok && coef_sel_e'(host_sel) == SEL_OFS);
    gain_we     = host_we && host_col_ok && coef_sel_e'(host_sel) == SEL_GAIN;
    ofs_waddr   = dk_we ? px_addr : host_addr;
    ofs_wdata   = dk_we ? in_pix  : host_data;
  end

  shade_coef_mem #(.W(PIX_W), .DEPTH(MEM_DEPTH)) u_ofs_mem (
    .clk(clk), .we(ofs_we), .waddr(ofs_waddr), .wdata(ofs_wdata),
    .re(px_take), .raddr(px_addr), .rdata(ofs_rd)
  );

  shade_coef_mem #(.W(PIX_W), .DEPTH(MEM_DEPTH)) u_gain_mem (
    .clk(clk), .we(gain_we), .waddr(host_addr), .wdata(host_data),
    .re(px_take), .raddr(px_addr), .rdata(gain_rd)
  );

  // stage 1: sample and coefficients
  logic             v1;
  logic [PIX_W-1:0] pix1;
  logic [IDX_W-1:0] idx1;
  logic [COL_W-1:0] col1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= px_take;
  end

  always_ff @(posedge clk) begin
    if (px_take) begin
      pix1 <= in_pix;
      idx1 <= in_idx;
      col1 <= in_col;
    end
  end

  // stage 2: offset removal
  logic [PIX_W-1:0] pofs1, diff_n;
  logic             v2;
  logic [PIX_W-1:0] diff2, gain2;
  logic [IDX_W-1:0] idx2;
  logic [COL_W-1:0] col2;

  always_comb pofs1 = idx1[0] ? par_ofs_odd : par_ofs_even;

  shade_sub #(.W(PIX_W)) u_sub (
    .pix(pix1), .ofs(ofs_rd), .pofs(pofs1), .diff(diff_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
  end

  always_ff @(posedge clk) begin
    if (v1) begin
      diff2 <= diff_n;
      gain2 <= gain_rd;
      idx2  <= idx1;
      col2  <= col1;
    end
  end

  // stage 3: gain, round, saturate
  logic [PIX_W-1:0] res_n;

  shade_mul #(.W(PIX_W), .FRAC(FRAC)) u_mul (
    .diff(diff2), .gain(gain2), .res(res_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_idx   <= '0;
      out_col   <= '0;
    end else begin
      out_valid <= v2;
      if (v2) begin
        out_pix <= res_n;
        out_idx <= idx2;
        out_col <= col2;
      end
    end
  end
endmodule

// File: rtl/shade_corr_chk.sv
module shade_corr_chk #(
  parameter int PIX_W = 16,
  parameter int IDX_W = 10,
  parameter int COL_W = 2,
  parameter int NCOL  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_dark,
  input logic             in_valid,
  input logic [COL_W-1:0] in_col,
  input logic [IDX_W-1:0] in_idx,
  input logic [PIX_W-1:0] in_pix,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_idx,
  input logic [PIX_W-1:0] out_pix,
  input logic [PIX_W-1:0] sub_pix,
  input logic [PIX_W-1:0] sub_diff
);
  logic [1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen == 2'd3 |-> out_valid == $past(in_valid && !cap_dark && (in_col < COL_W'(NCOL)), 3));

  p_idx_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3 && out_valid) |-> out_idx == $past(in_idx, 3));

  p_dark_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3 && out_valid) |-> !$past(cap_dark, 3));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_diff <= sub_pix);

  p_zero_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3 && out_valid && $past(in_pix, 3) == '0) |-> out_pix == '0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3 && !out_valid) |-> $stable(out_pix));
endmodule

bind shade_corr_top shade_corr_chk #(
  .PIX_W(PIX_W), .IDX_W(IDX_W), .COL_W(COL_W), .NCOL(NCOL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_dark(cap_dark), .in_valid(in_valid),
  .in_col(in_col), .in_idx(in_idx), .in_pix(in_pix), .out_valid(out_valid),
  .out_idx(out_idx), .out_pix(out_pix), .sub_pix(pix1), .sub_diff(diff_n)
);

// File: tb/sim_shade_corr_top.sv
module sim_shade_corr_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_dark;
  logic [15:0] par_ofs_odd, par_ofs_even;
  logic        host_we, host_sel;
  logic [1:0]  host_col;
  logic [9:0]  host_idx;
  logic [15:0] host_data;
  logic        in_valid;
  logic [1:0]  in_col;
  logic [9:0]  in_idx;
  logic [15:0] in_pix;
  logic        out_valid;
  logic [1:0]  out_col;
  logic [9:0]  out_idx;
  logic [15:0] out_pix;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  shade_corr_top u0 (
    .clk(clk), .rst_n(rst_n), .cap_dark(cap_dark),
    .par_ofs_odd(par_ofs_odd), .par_ofs_even(par_ofs_even),
    .host_we(host_we), .host_sel(host_sel), .host_col(host_col),
    .host_idx(host_idx), .host_data(host_data),
    .in_valid(in_valid), .in_col(in_col), .in_idx(in_idx), .in_pix(in_pix),
    .out_valid(out_valid), .out_col(out_col), .out_idx(out_idx), .out_pix(out_pix)
  );

  function automatic int model(int pix, int ofs, int pofs, int gain);
    longint d, p;
    d = (pix > ofs + pofs) ? pix - ofs - pofs : 0;
    p = (d * gain + 8192) >>> 14;
    return (p > 65535) ? 65535 : int'(p);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hwrite(bit sel, int col, int idx, int data);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_col = 2'(col);
    host_idx = 10'(idx); host_data = 16'(data);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_coef(int col, int idx, int ofs, int gain);
    hwrite(1'b0, col, idx, ofs);
    hwrite(1'b1, col, idx, gain);
  endtask

  // one pixel, checked for three-cycle latency and value
  task automatic one_pix(int col, int idx, int pix, int exp, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_col = 2'(col); in_idx = 10'(idx); in_pix = 16'(pix);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, {tag, " early valid"}, int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, {tag, " early valid"}, int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
    chk(out_pix == 16'(exp), {tag, " value"}, int'(out_pix), exp);
    chk(out_idx == 10'(idx) && out_col == 2'(col), {tag, " tag"}, int'(out_idx), idx);
  endtask

  task automatic quiet_pix(int col, int idx, int pix, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_col = 2'(col); in_idx = 10'(idx); in_pix = 16'(pix);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(out_valid == 1'b0, {tag, " no output"}, int'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(out_pix == 16'd0, "R1 pix", int'(out_pix), 0);
  endtask

  task automatic t_unity;
    set_coef(0, 4, 100, 16'h4000);
    one_pix(0, 4, 1100, 1000, "R3 R8 R2 unity");
  endtask

  task automatic t_round;
    set_coef(0, 8, 0, 16'h6000);
    one_pix(0, 8, 1001, model(1001, 0, 0, 16'h6000), "R3 round");
  endtask

  task automatic t_clamp;
    set_coef(0, 10, 2000, 16'h4000);
    one_pix(0, 10, 1500, 0, "R4 clamp");
  endtask

  task automatic t_sat;
    set_coef(0, 12, 0, 16'hFFFF);
    one_pix(0, 12, 60000, 65535, "R5 saturate");
  endtask

  task automatic t_parity;
    set_coef(0, 6, 0, 16'h4000);
    set_coef(0, 7, 0, 16'h4000);
    par_ofs_odd = 16'd10; par_ofs_even = 16'd3;
    one_pix(0, 6, 500, 497, "R6 even");
    one_pix(0, 7, 500, 490, "R6 odd");
    par_ofs_odd = 16'd0; par_ofs_even = 16'd0;
  endtask

  task automatic t_colour;
    set_coef(1, 4, 0, 16'h8000);
    one_pix(1, 4, 300, 600, "R9 colour1");
    one_pix(0, 4, 300, 200, "R9 colour0");
    quiet_pix(3, 4, 300, "R9 colour3");
  endtask

  task automatic t_write_timing;
    set_coef(2, 20, 0, 16'h4000);
    @(negedge clk);
    host_we = 1'b1; host_sel = 1'b1; host_col = 2'd2; host_idx = 10'd20;
    host_data = 16'h2000;
    @(negedge clk);
    host_we = 1'b0;
    in_valid = 1'b1; in_col = 2'd2; in_idx = 10'd20; in_pix = 16'd800;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid && out_pix == 16'd400, "R8 next-cycle gain", int'(out_pix), 400);
  endtask

  task automatic t_dark;
    @(negedge clk);
    cap_dark = 1'b1;
    quiet_pix(2, 9, 777, "R7 dark a");
    quiet_pix(2, 10, 50, "R7 dark b");
    cap_dark = 1'b0;
    hwrite(1'b1, 2, 9, 16'h4000);
    hwrite(1'b1, 2, 10, 16'h4000);
    one_pix(2, 9, 1000, 223, "R7 stored a");
    one_pix(2, 10, 1000, 950, "R7 stored b");
  endtask

  task automatic t_prio;
    hwrite(1'b1, 2, 12, 16'h4000);
    @(negedge clk);
    cap_dark = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_col = 2'd2; in_idx = 10'd12; in_pix = 16'd40;
    host_we = 1'b1; host_sel = 1'b0; host_col = 2'd2; host_idx = 10'd12;
    host_data = 16'd500;
    @(negedge clk);
    in_valid = 1'b0; host_we = 1'b0;
    @(negedge clk);
    cap_dark = 1'b0;
    repeat (3) @(negedge clk);
    one_pix(2, 12, 1000, 960, "R11 dark wins");
  endtask

  task automatic t_hold;
    one_pix(0, 4, 1100, 1000, "R10 setup");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!out_valid && out_pix == 16'd1000, "R10 hold", int'(out_pix), 1000);
    end
  endtask

  task automatic t_burst;
    int px [4] = '{1100, 1200, 1300, 1400};
    int ix [4] = '{4, 8, 6, 7};
    int ex [4];
    ex[0] = 1000; ex[1] = model(1200, 0, 0, 16'h6000);
    ex[2] = 1300; ex[3] = 1400;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        chk(out_valid == 1'b1, "R2 burst valid", int'(out_valid), 1);
        chk(out_pix == 16'(ex[i-3]), "R2 burst value", int'(out_pix), ex[i-3]);
        chk(out_idx == 10'(ix[i-3]), "R2 burst idx", int'(out_idx), ix[i-3]);
      end
      if (i < 4) begin
        in_valid = 1'b1; in_col = 2'd0; in_idx = 10'(ix[i]); in_pix = 16'(px[i]);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 burst end", int'(out_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; cap_dark = 1'b0; par_ofs_odd = '0; par_ofs_even = '0;
    host_we = 1'b0; host_sel = 1'b0; host_col = '0; host_idx = '0; host_data = '0;
    in_valid = 1'b0; in_col = '0; in_idx = '0; in_pix = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_unity;
    t_round;
    t_clamp;
    t_sat;
    t_parity;
    t_colour;
    t_write_timing;
    t_dark;
    t_prio;
    t_hold;
    t_burst;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule